// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block keeps the eight interrupt flags of a CAN controller and turns them into one interrupt request. The flags are set by three kinds of source. The first is threshold crossings of the transmit and receive error counters. The second is single-cycle event pulses for a transmitted overload frame and for the end of reset processing. The third is per-mailbox receive-pending and remote-request-pending vectors, filtered by a per-mailbox interrupt mask. Software sees the flags in the upper byte of a 16-bit register. It clears most of them by writing 1. The two mailbox flags ignore writes and drop by themselves once no unmasked mailbox has anything pending.

The error counters, the mailboxes and the protocol engine live elsewhere. They reach this block only as input signals. Each flag has its own enable input, and the interrupt request output is high while any enabled flag is set.

Top module: `canirq_flags`

## Requirements
- R1: After synchronous reset, `rd_data` reads 16'h0100: the reset-indication flag (bit 8) is 1 and every other bit is 0.
- R2: Writing with `wr_en` high clears each of bits 8, 11, 12, 13, 14 and 15 whose `wr_data` bit is 1. Bits written with 0 are unchanged. Bits 9 and 10 ignore writes entirely.
- R3: A pulse on `rst_done` sets bit 8. Every flag update takes effect at the clock edge that samples its cause, and is visible on `rd_data` from the following cycle.
- R4: Bit 9 (receive message) sets when a `rx_pend` bit of a mailbox whose `mbox_mask` bit is 0 goes from 0 to 1. It clears at the first edge where no unmasked mailbox has `rx_pend` set. A mask bit of 1 means the mailbox is masked.
- R5: Bit 10 (remote request) behaves like bit 9, using `rr_pend` in place of `rx_pend`.
- R6: Bit 11 sets when `tec` enters the range `tec` >= 96. Bit 12 sets when `rec` enters the range `rec` >= 96.
- R7: Bit 13 (bus off) sets when `tec` enters the range `tec` >= 256. `rec` never sets it.
- R8: Bit 15 (error passive) sets when the condition (`tec` >= 128 or `rec` >= 128) becomes true.
- R9: The threshold flags (bits 11, 12, 13, 15) are set only on entry into their condition. They stay set after the condition ends. When cleared while the condition still holds, they stay 0 until the condition ends and is entered again.
- R10: A pulse on `ovl_tx` sets bit 14.
- R11: When a set cause and a write-1 clear of the same flag fall in the same cycle, the flag ends up 1.
- R12: `irq` is 1 exactly when some register bit 8+k is 1 while `irq_en[k]` is 1, for k = 0 to 7.
- R13: `rd_data[7:0]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tec | input | CNT_W | Transmit error counter value |
| rec | input | CNT_W | Receive error counter value |
| ovl_tx | input | 1 | Pulse: an overload frame was transmitted |
| rst_done | input | 1 | Pulse: reset processing of the controller has finished |
| rx_pend | input | NUM_MBOX | Per-mailbox receive-pending bits |
| rr_pend | input | NUM_MBOX | Per-mailbox remote-request-pending bits |
| mbox_mask | input | NUM_MBOX | Per-mailbox interrupt mask, 1 = masked |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; a 1 clears the matching clearable flag |
| rd_data | output | 16 | Register value: flags in bits 15..8, zeros below |
| irq_en | input | 8 | Per-flag interrupt enables, bit k enables register bit 8+k |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with four mailboxes and 9-bit counters. With four mailboxes, every combination of mask and pending pattern can be applied to both mailbox vectors, including patterns where only masked mailboxes remain pending. The 9-bit counters let both counters be swept one step at a time past 96, 128 and 256, and back down. These counters also allow a single jump straight over all three thresholds. All 256 enable patterns are applied against a full flag set and against a partial flag set.

// File: rtl/canirq_pkg.sv
package canirq_pkg;

    localparam int FLAG_N   = 8;
    localparam int FLAG_LSB = 8;
    localparam int REG_W    = 16;

    // flag positions within the flag byte (register bit = FLAG_LSB + index)
    localparam int F_RST  = 0;
    localparam int F_RXM  = 1;
    localparam int F_RRQ  = 2;
    localparam int F_TXW  = 3;
    localparam int F_RXW  = 4;
    localparam int F_BOFF = 5;
    localparam int F_OVL  = 6;
    localparam int F_EPAS = 7;

    // flags software can clear with a written 1
    localparam logic [FLAG_N-1:0] W1C_MASK  = 8'b1111_1001;
    localparam logic [FLAG_N-1:0] RESET_VAL = 8'b0000_0001;

    typedef struct packed {
        logic epas;
        logic ovl;
        logic boff;
        logic rxw;
        logic txw;
        logic rrq;
        logic rxm;
        logic rst;
    } flags_t;

    typedef struct packed {
        logic epas;
        logic boff;
        logic rxw;
        logic txw;
    } thr_t;

    function automatic logic at_least(input logic [31:0] value, input int unsigned level);
        return value >= level;
    endfunction

endpackage

// File: rtl/canirq_thresh.sv
module canirq_thresh
    import canirq_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128,
    parameter int BUSOFF_LVL  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    output thr_t             rise
);

    thr_t cond;
    thr_t cond_q;

    always_comb begin
        cond.txw  = at_least(32'(tec), WARN_LVL);
        cond.rxw  = at_least(32'(rec), WARN_LVL);
        cond.boff = at_least(32'(tec), BUSOFF_LVL);
        cond.epas = at_least(32'(tec), PASSIVE_LVL) | at_least(32'(rec), PASSIVE_LVL);
    end

    always_ff @(posedge clk) begin
        if (rst) cond_q <= '0;
        else     cond_q <= cond;
    end

    // entry into a state is its rising edge
    assign rise = thr_t'(cond & ~cond_q);

endmodule

// File: rtl/canirq_mbox_sum.sv
module canirq_mbox_sum #(
    parameter int NUM_MBOX = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_MBOX-1:0] pend,
    input  logic [NUM_MBOX-1:0] mask,
    output logic                new_evt,
    output logic                live
);

    logic [NUM_MBOX-1:0] pend_q;
    logic [NUM_MBOX-1:0] fresh;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend;
    end

    genvar m;
    generate
        for (m = 0; m < NUM_MBOX; m++) begin : g_mbox
            assign fresh[m] = pend[m] & ~pend_q[m] & ~mask[m];
        end
    endgenerate

    assign new_evt = |fresh;
    assign live    = |(pend & ~mask);

endmodule

// File: rtl/canirq_flag_bank.sv
module canirq_flag_bank
    import canirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_N-1:0] set_v,
    input  logic [FLAG_N-1:0] hold_v,
    input  logic [FLAG_N-1:0] clr_v,
    output logic [FLAG_N-1:0] q
);

    logic [FLAG_N-1:0] nxt;

    genvar i;
    generate
        for (i = 0; i < FLAG_N; i++) begin : g_flag
            // a set always overrides a clear in the same cycle
            assign nxt[i] = set_v[i] | (q[i] & hold_v[i] & ~clr_v[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= RESET_VAL;
        else     q <= nxt;
    end

endmodule

// File: rtl/canirq_flags.sv
module canirq_flags
    import canirq_pkg::*;
#(
    parameter int NUM_MBOX    = 16,
    parameter int CNT_W       = 9,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128,
    parameter int BUSOFF_LVL  = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    tec,
    input  logic [CNT_W-1:0]    rec,
    input  logic                ovl_tx,
    input  logic                rst_done,
    input  logic [NUM_MBOX-1:0] rx_pend,
    input  logic [NUM_MBOX-1:0] rr_pend,
    input  logic [NUM_MBOX-1:0] mbox_mask,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic [FLAG_N-1:0]   irq_en,
    output logic                irq
);

    thr_t   thr_rise;
    logic   rx_new, rx_live;
    logic   rr_new, rr_live;
    flags_t set_s;
    flags_t hold_s;
    logic [FLAG_N-1:0] clr_v;
    logic [FLAG_N-1:0] flag_q;
    logic   unused_lo;

    canirq_thresh #(
        .CNT_W      (CNT_W),
        .WARN_LVL   (WARN_LVL),
        .PASSIVE_LVL(PASSIVE_LVL),
        .BUSOFF_LVL (BUSOFF_LVL)
    ) thresh_i (
        .clk (clk),
        .rst (rst),
        .tec (tec),
        .rec (rec),
        .rise(thr_rise)
    );

    canirq_mbox_sum #(.NUM_MBOX(NUM_MBOX)) rx_sum_i (
        .clk    (clk),
        .rst    (rst),
        .pend   (rx_pend),
        .mask   (mbox_mask),
        .new_evt(rx_new),
        .live   (rx_live)
    );

    canirq_mbox_sum #(.NUM_MBOX(NUM_MBOX)) rr_sum_i (
        .clk    (clk),
        .rst    (rst),
        .pend   (rr_pend),
        .mask   (mbox_mask),
        .new_evt(rr_new),
        .live   (rr_live)
    );

    always_comb begin
        set_s.rst  = rst_done;
        set_s.rxm  = rx_new;
        set_s.rrq  = rr_new;
        set_s.txw  = thr_rise.txw;
        set_s.rxw  = thr_rise.rxw;
        set_s.boff = thr_rise.boff;
        set_s.ovl  = ovl_tx;
        set_s.epas = thr_rise.epas;

        hold_s      = '1;
        hold_s.rxm  = rx_live;
        hold_s.rrq  = rr_live;
    end

    assign clr_v = wr_en ? (wr_data[FLAG_LSB +: FLAG_N] & W1C_MASK) : '0;
    assign unused_lo = ^wr_data[FLAG_LSB-1:0];

    canirq_flag_bank bank_i (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_s),
        .hold_v(hold_s),
        .clr_v (clr_v),
        .q     (flag_q)
    );

    assign rd_data = {flag_q, {FLAG_LSB{1'b0}}};
    assign irq     = |(flag_q & irq_en);

endmodule

// File: rtl/canirq_flags_chk.sv
module canirq_flags_chk #(
    parameter int NUM_MBOX    = 16,
    parameter int CNT_W       = 9,
    parameter int BUSOFF_LVL  = 256
) (
    input logic                clk,
    input logic                rst,
    input logic [CNT_W-1:0]    tec,
    input logic                ovl_tx,
    input logic                rst_done,
    input logic [NUM_MBOX-1:0] rx_pend,
    input logic [NUM_MBOX-1:0] rr_pend,
    input logic [NUM_MBOX-1:0] mbox_mask,
    input logic                wr_en,
    input logic [15:0]         wr_data,
    input logic [15:0]         rd_data,
    input logic [7:0]          irq_en,
    input logic                irq
);

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> rd_data[15:8] == 8'h01);

    assert_w1c_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[14] && !ovl_tx) |=> !rd_data[14]);

    assert_no_spurious_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[15]) |-> $past(wr_en && wr_data[15]));

    assert_rst_done_set_R3: assert property (@(posedge clk) disable iff (rst)
        rst_done |=> rd_data[8]);

    assert_rx_live_clear_R4: assert property (@(posedge clk) disable iff (rst)
        ((rx_pend & ~mbox_mask) == '0) |=> !rd_data[9]);

    assert_rr_live_clear_R5: assert property (@(posedge clk) disable iff (rst)
        ((rr_pend & ~mbox_mask) == '0) |=> !rd_data[10]);

    assert_busoff_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(tec) >= BUSOFF_LVL && !$past(32'(tec) >= BUSOFF_LVL)) |=> rd_data[13]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (ovl_tx && wr_en && wr_data[14]) |=> rd_data[14]);

    assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        ((rd_data[15:8] & irq_en) == 8'h00) |-> !irq);

endmodule

bind canirq_flags canirq_flags_chk #(
    .NUM_MBOX  (NUM_MBOX),
    .CNT_W     (CNT_W),
    .BUSOFF_LVL(BUSOFF_LVL)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .tec      (tec),
    .ovl_tx   (ovl_tx),
    .rst_done (rst_done),
    .rx_pend  (rx_pend),
    .rr_pend  (rr_pend),
    .mbox_mask(mbox_mask),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq_en   (irq_en),
    .irq      (irq)
);

// File: tb/canirq_flags_tb_top.sv
module canirq_flags_tb_top;

    localparam int CLK_P = 10;
    localparam int NMB   = 4;
    localparam int CW    = 9;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [CW-1:0]  tec = '0;
    logic [CW-1:0]  rec = '0;
    logic           ovl_tx = 1'b0;
    logic           rst_done = 1'b0;
    logic [NMB-1:0] rx_pend = '0;
    logic [NMB-1:0] rr_pend = '0;
    logic [NMB-1:0] mbox_mask = '0;
    logic           wr_en = 1'b0;
    logic [15:0]    wr_data = '0;
    logic [15:0]    rd_data;
    logic [7:0]     irq_en = '0;
    logic           irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    canirq_flags #(.NUM_MBOX(NMB), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .tec(tec), .rec(rec),
        .ovl_tx(ovl_tx), .rst_done(rst_done),
        .rx_pend(rx_pend), .rr_pend(rr_pend), .mbox_mask(mbox_mask),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic set_pend(input int sel, input logic [NMB-1:0] v);
        if (sel == 0) rx_pend = v;
        else          rr_pend = v;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        chk("R1 reset value", 32'(rd_data), 32'h0100);
        tick();
        chk("R1 value held", 32'(rd_data), 32'h0100);

        // R2 / R13: zeros and low-byte ones change nothing
        wr(16'h00FF);
        chk("R13 low byte write", 32'(rd_data), 32'h0100);
        wr(16'h0000);
        chk("R2 write zero", 32'(rd_data), 32'h0100);
        wr(16'h0100);
        chk("R2 clear bit 8", 32'(rd_data), 32'h0000);

        // R3
        rst_done = 1'b1;
        tick();
        rst_done = 1'b0;
        chk("R3 reset done sets bit 8", 32'(rd_data), 32'h0100);
        wr(16'h0100);
        chk("R2 clear bit 8 again", 32'(rd_data), 32'h0000);

        // transmit counter sweep upward
        for (int v = 0; v <= 300; v++) begin
            tec = CW'(v);
            tick();
            chk("R6 tx warn", 32'(rd_data[11]), 32'(v >= 96));
            chk("R8 passive via tec", 32'(rd_data[15]), 32'(v >= 128));
            chk("R7 bus off", 32'(rd_data[13]), 32'(v >= 256));
            chk("R6 rx warn idle", 32'(rd_data[12]), 32'h0);
        end
        for (int v = 300; v >= 0; v--) begin
            tec = CW'(v);
            tick();
            chk("R9 sticky after fall", 32'(rd_data), 32'hA800);
        end
        wr(16'hFF00);
        chk("R2 clear all", 32'(rd_data), 32'h0000);

        // jump over all thresholds, then clear while held
        tec = CW'(300);
        tick();
        chk("R7 jump entry", 32'(rd_data), 32'hA800);
        wr(16'hFF00);
        chk("R9 clear while held", 32'(rd_data), 32'h0000);
        tick();
        tick();
        chk("R9 no re-set while held", 32'(rd_data), 32'h0000);
        tec = '0;
        tick();

        // receive counter sweep
        for (int v = 0; v <= 300; v++) begin
            rec = CW'(v);
            tick();
            chk("R6 rx warn", 32'(rd_data[12]), 32'(v >= 96));
            chk("R8 passive via rec", 32'(rd_data[15]), 32'(v >= 128));
            chk("R7 rec no bus off", 32'(rd_data[13]), 32'h0);
            chk("R6 tx warn idle", 32'(rd_data[11]), 32'h0);
        end
        rec = '0;
        tick();
        wr(16'hFF00);
        chk("R2 clear after rec", 32'(rd_data), 32'h0000);

        // R10 / R11
        ovl_tx = 1'b1;
        tick();
        ovl_tx = 1'b0;
        chk("R10 overload", 32'(rd_data), 32'h4000);
        wr(16'h4000);
        chk("R2 clear overload", 32'(rd_data), 32'h0000);
        ovl_tx = 1'b1;
        wr(16'h4000);
        ovl_tx = 1'b0;
        chk("R11 set wins overload", 32'(rd_data), 32'h4000);
        wr(16'h4000);
        tec = CW'(100);
        wr(16'h0800);
        chk("R11 set wins tx warn", 32'(rd_data), 32'h0800);
        tec = '0;
        tick();
        wr(16'hFF00);
        chk("R2 clear before mailbox", 32'(rd_data), 32'h0000);

        // mailbox sweep: sel 0 -> bit 9 (R4), sel 1 -> bit 10 (R5)
        for (int sel = 0; sel < 2; sel++) begin
            rx_pend = '0;
            rr_pend = '0;
            for (int m = 0; m < 16; m++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [NMB-1:0] pv;
                    logic [NMB-1:0] mv;
                    logic [31:0]    expv;
                    pv = NMB'(p);
                    mv = NMB'(m);
                    mbox_mask = mv;
                    set_pend(sel, '0);
                    tick();
                    chk(sel ? "R5 idle" : "R4 idle", 32'(rd_data), 32'h0000);
                    set_pend(sel, pv);
                    tick();
                    expv = ((pv & ~mv) != '0) ? (32'h1 << (9 + sel)) : 32'h0;
                    chk(sel ? "R5 set" : "R4 set", 32'(rd_data), expv);
                    wr(16'h0600);
                    chk("R2 mailbox flag ignores write", 32'(rd_data), expv);
                    set_pend(sel, pv & mv);
                    tick();
                    chk(sel ? "R5 clear masked left" : "R4 clear masked left",
                        32'(rd_data), 32'h0000);
                end
            end
        end

        // R12: every flag set
        rx_pend = '0;
        rr_pend = '0;
        mbox_mask = '0;
        tick();
        tec = CW'(300);
        rec = CW'(300);
        ovl_tx = 1'b1;
        rst_done = 1'b1;
        rx_pend = 4'b0001;
        rr_pend = 4'b0001;
        tick();
        ovl_tx = 1'b0;
        rst_done = 1'b0;
        chk("R12 all flags set", 32'(rd_data), 32'hFF00);
        for (int e = 0; e < 256; e++) begin
            irq_en = 8'(e);
            #1;
            chk("R12 irq full", 32'(irq), 32'(e != 0));
        end
        irq_en = '0;
        tick();
        wr(16'h5555);
        chk("R2 partial clear", 32'(rd_data), 32'hAE00);
        chk("R13 low byte zero", 32'(rd_data[7:0]), 32'h0);
        for (int e = 0; e < 256; e++) begin
            irq_en = 8'(e);
            #1;
            chk("R12 irq partial", 32'(irq), 32'((8'(e) & 8'hAE) != 8'h00));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule